// File: doc/BRIEF.md
# Vector complex integer adder with quarter-turn rotation

This block treats a packed vector as a row of complex numbers. Each complex number is two neighbouring signed elements: the lower-indexed one is the real part and the next one up is the imaginary part. The block adds to the first vector a second vector that has been turned by a quarter turn (90 degrees) or three quarter turns (270 degrees) in the complex plane. Because of the rotation, each real part is paired with the other operand's imaginary part, and each imaginary part with the other operand's real part. The add and subtract swap places when the rotation direction changes. The element width is 8, 16, 32 or 64 bits. Each add or subtract can wrap, or it can clamp to the signed range of the element.

All controls are decoded from a 32-bit instruction word. The register numbers carried in that word are passed along with the result, so the caller knows where to write it back. A word whose fixed bit fields do not match the pattern is flagged illegal, and the first source then passes through unchanged.

Operands enter on a valid/ready stream, and the result leaves on a second valid/ready stream after one registered stage. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds every field steady and no new input is accepted. No bubble is inserted when both sides are ready, so the block can take one operation per cycle.

Top module: `cplx_rot_add`

## Requirements
- R1: The instruction word is legal only when bits 31..24 equal 8'h45, bits 21..17 are zero and bits 15..11 equal 5'b11011. Otherwise `out_illegal` is 1 and `out_result` equals the first source as accepted.
- R2: With bit 10 = 0 (90 degrees), for every pair: result real = first real − second imaginary, and result imaginary = first imaginary + second real.
- R3: With bit 10 = 1 (270 degrees), for every pair: result real = first real + second imaginary, and result imaginary = first imaginary − second real.
- R4: Bits 23..22 select the element width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. Element k occupies bits [k*EW +: EW], and pair p uses elements 2p (real part) and 2p+1 (imaginary part).
- R5: With bit 16 = 1, a result above the signed maximum becomes the 0x7F.. pattern of the element width.
- R6: With bit 16 = 1, a result below the signed minimum becomes the 0x80.. pattern of the element width.
- R7: With bit 16 = 0, each result wraps modulo 2^EW.
- R8: `out_dst_reg` carries bits 4..0 of the accepted word, and `out_src_reg` carries bits 9..5.
- R9: After reset `out_valid` is 0. An operation accepted on one edge appears with `out_valid` = 1 after that edge.
- R10: While `out_valid` = 1 and `out_ready` = 0, all outputs hold their values and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can accept an operation |
| in_insn | input | 32 | Instruction word carrying the controls |
| in_src_a | input | W | First source (also the destination operand) |
| in_src_b | input | W | Second source, the one that is rotated |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | W | Result vector |
| out_illegal | output | 1 | The accepted word failed the fixed-field check |
| out_dst_reg | output | 5 | Destination / first source register number |
| out_src_reg | output | 5 | Second source register number |

## Verification
The hardest case to reach is clamping on both sides at once. One pair can overflow upward in one half and downward in the other, and the bound it clamps to depends on both the rotation and the element width. The stimulus builds operand vectors from replicated extreme element values (the signed maximum, the signed minimum, and values next to them) at each width and in both rotations. Every lane is then compared with an independent bench model. Back-pressure is exercised by holding `out_ready` low for several cycles while a new operation waits at the input.

// File: rtl/cadd_pkg.sv
package cadd_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } esz_t;

  typedef struct packed {
    esz_t       esz;
    logic       rot270;
    logic       sat;
    logic       illegal;
    logic [4:0] dst_reg;
    logic [4:0] src_reg;
  } cadd_ctl_t;

  localparam logic [7:0] OPC_HI  = 8'h45;
  localparam logic [4:0] OPC_MID = 5'b11011;
endpackage

// File: rtl/cadd_decode.sv
module cadd_decode
  import cadd_pkg::*;
(
  input  logic [31:0] insn,
  output cadd_ctl_t   ctl
);
  logic hi_ok, zero_ok, mid_ok;

  always_comb begin
    hi_ok   = (insn[31:24] == OPC_HI);
    zero_ok = (insn[21:17] == 5'd0);
    mid_ok  = (insn[15:11] == OPC_MID);
    ctl.esz     = esz_t'(insn[23:22]);
    ctl.sat     = insn[16];
    ctl.rot270  = insn[10];
    ctl.src_reg = insn[9:5];
    ctl.dst_reg = insn[4:0];
    ctl.illegal = !(hi_ok && zero_ok && mid_ok);
  end
endmodule

// File: rtl/cadd_sat_addsub.sv
module cadd_sat_addsub #(
  parameter int EW = 8
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          sub,
  input  logic          sat,
  output logic [EW-1:0] y
);
  localparam logic [EW-1:0] SMAX = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] SMIN = {1'b1, {(EW-1){1'b0}}};

  logic [EW:0] ext;
  logic        ovf;

  always_comb begin
    if (sub) ext = {a[EW-1], a} - {b[EW-1], b};
    else     ext = {a[EW-1], a} + {b[EW-1], b};
    ovf = ext[EW] ^ ext[EW-1];
    if (sat && ovf) y = ext[EW] ? SMIN : SMAX;
    else            y = ext[EW-1:0];
  end

  // R5: a saturating sum of two non-negatives never turns negative
  always_comb begin
    if (sat && !sub && !a[EW-1] && !b[EW-1])
      p_no_pos_wrap_r5: assert (!y[EW-1]);
  end

  // R6: a saturating sum of two negatives never turns non-negative
  always_comb begin
    if (sat && !sub && a[EW-1] && b[EW-1])
      p_no_neg_wrap_r6: assert (y[EW-1]);
  end
endmodule

// File: rtl/cadd_vec.sv
module cadd_vec #(
  parameter int W  = 128,
  parameter int EW = 8
) (
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         rot270,
  input  logic         sat,
  output logic [W-1:0] res
);
  localparam int NPAIR = W / (2 * EW);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int RE = 2 * p * EW;
    localparam int IM = RE + EW;

    // real: a.re -/+ b.im ; imag: a.im +/- b.re
    cadd_sat_addsub #(.EW(EW)) u_re (
      .a  (src_a[RE +: EW]),
      .b  (src_b[IM +: EW]),
      .sub(!rot270),
      .sat(sat),
      .y  (res[RE +: EW])
    );

    cadd_sat_addsub #(.EW(EW)) u_im (
      .a  (src_a[IM +: EW]),
      .b  (src_b[RE +: EW]),
      .sub(rot270),
      .sat(sat),
      .y  (res[IM +: EW])
    );
  end
endmodule

// File: rtl/cplx_rot_add.sv
module cplx_rot_add
  import cadd_pkg::*;
#(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_insn,
  input  logic [W-1:0] in_src_a,
  input  logic [W-1:0] in_src_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_illegal,
  output logic [4:0]   out_dst_reg,
  output logic [4:0]   out_src_reg
);
  localparam int NSZ = 4;

  cadd_ctl_t              ctl;
  logic [NSZ-1:0][W-1:0]  by_size;
  logic [W-1:0]           next_res;
  logic                   take;

  cadd_decode u_dec (
    .insn(in_insn),
    .ctl (ctl)
  );

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    cadd_vec #(.W(W), .EW(8 << s)) u_vec (
      .src_a (in_src_a),
      .src_b (in_src_b),
      .rot270(ctl.rot270),
      .sat   (ctl.sat),
      .res   (by_size[s])
    );
  end

  always_comb begin
    if (ctl.illegal) next_res = in_src_a;
    else             next_res = by_size[ctl.esz];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
      out_dst_reg <= '0;
      out_src_reg <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= next_res;
        out_illegal <= ctl.illegal;
        out_dst_reg <= ctl.dst_reg;
        out_src_reg <= ctl.src_reg;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: an accepted operation is presented on the next cycle
  p_accept_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10: a stalled result is held steady and the input is blocked
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_dst_reg) && $stable(out_illegal));

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1: an illegal word returns the first source untouched
  p_illegal_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(take) && $past(ctl.illegal)
      |-> out_illegal && out_result == $past(in_src_a));
endmodule

// File: tb/cplx_rot_add_tb.sv
module cplx_rot_add_tb;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [W-1:0] in_src_a = '0;
  logic [W-1:0] in_src_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic         out_illegal;
  logic [4:0]   out_dst_reg;
  logic [4:0]   out_src_reg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cplx_rot_add #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
    .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_illegal(out_illegal), .out_dst_reg(out_dst_reg), .out_src_reg(out_src_reg)
  );

  function automatic logic [31:0] mk_insn(input logic [1:0] sz, input bit sat,
                                          input bit rot, input logic [4:0] rm,
                                          input logic [4:0] rd);
    return {8'h45, sz, 5'b00000, sat, 5'b11011, rot, rm, rd};
  endfunction

  function automatic logic [W-1:0] fill(input logic [1:0] sz, input logic [63:0] ev);
    logic [W-1:0] v;
    int ew;
    ew = 8 << sz;
    v = '0;
    for (int k = 0; k < W; k++) v[k] = ev[k % ew];
    return v;
  endfunction

  function automatic logic signed [65:0] getel(input logic [W-1:0] v, input int idx, input int ew);
    logic signed [65:0] e;
    for (int k = 0; k < 66; k++) e[k] = (k < ew) ? v[idx*ew + k] : v[idx*ew + ew - 1];
    return e;
  endfunction

  function automatic logic [W-1:0] model(input logic [1:0] sz, input bit sat, input bit rot,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic signed [65:0] ar, ai, br, bi, yr, yi, mx, mn;
    int ew;
    ew = 8 << sz;
    mx = (66'sd1 <<< (ew - 1)) - 66'sd1;
    mn = -(66'sd1 <<< (ew - 1));
    r = '0;
    for (int p = 0; p < W / (2 * ew); p++) begin
      ar = getel(a, 2*p, ew);   ai = getel(a, 2*p+1, ew);
      br = getel(b, 2*p, ew);   bi = getel(b, 2*p+1, ew);
      if (rot) begin yr = ar + bi; yi = ai - br; end
      else     begin yr = ar - bi; yi = ai + br; end
      if (sat) begin
        if (yr > mx) yr = mx; if (yr < mn) yr = mn;
        if (yi > mx) yi = mx; if (yi < mn) yi = mn;
      end
      for (int k = 0; k < ew; k++) begin
        r[2*p*ew + k]      = yr[k];
        r[(2*p+1)*ew + k]  = yi[k];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input bit ok, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] insn, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_src_a = a; in_src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [1:0] sz, input bit sat, input bit rot,
                        input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] exp;
    exp = model(sz, sat, rot, a, b);
    issue(mk_insn(sz, sat, rot, 5'd3, 5'd7), a, b);
    chk(req, out_valid && !out_illegal && out_result == exp, out_result, exp);
  endtask

  task automatic t_reset();
    chk("R9 reset", out_valid == 1'b0 && in_ready == 1'b1, {127'd0, out_valid}, '0);
  endtask

  task automatic t_rot90();
    for (int s = 0; s < 4; s++)
      run_op("R2/R4 rot90 wrap", 2'(s), 1'b0, 1'b0, {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom});
  endtask

  task automatic t_rot270();
    for (int s = 0; s < 4; s++)
      run_op("R3/R4 rot270 wrap", 2'(s), 1'b0, 1'b1, {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom});
  endtask

  task automatic t_sat_pos();
    logic [63:0] mx;
    for (int s = 0; s < 4; s++) begin
      mx = (64'd1 << ((8 << s) - 1)) - 64'd1;
      run_op("R5 clamp high rot90", 2'(s), 1'b1, 1'b0, fill(2'(s), mx), fill(2'(s), mx));
      run_op("R5 clamp high rot270", 2'(s), 1'b1, 1'b1, fill(2'(s), mx), fill(2'(s), ~mx));
    end
  endtask

  task automatic t_sat_neg();
    logic [63:0] mn;
    for (int s = 0; s < 4; s++) begin
      mn = 64'd1 << ((8 << s) - 1);
      run_op("R6 clamp low rot90", 2'(s), 1'b1, 1'b0, fill(2'(s), mn), fill(2'(s), mn));
      run_op("R6 clamp low rot270", 2'(s), 1'b1, 1'b1, fill(2'(s), mn), fill(2'(s), mn + 64'd1));
    end
    // explicit byte check: 0x80 + 0x80 at imag lanes with rot90 -> 0x80
    issue(mk_insn(2'b00, 1'b1, 1'b0, 5'd1, 5'd2), {16{8'h80}}, {16{8'h80}});
    chk("R6 byte pattern", out_result[15:8] == 8'h80, out_result, {16{8'h80}});
  endtask

  task automatic t_wrap();
    logic [W-1:0] exp;
    // 0x7F + 0x01 wraps to 0x80 in imag bytes; 0x7F - 0x01 real stays 0x7E
    exp = {8{8'h80, 8'h7E}};
    issue(mk_insn(2'b00, 1'b0, 1'b0, 5'd0, 5'd0), {16{8'h7F}}, {16{8'h01}});
    chk("R7 wrap", out_result == exp, out_result, exp);
    for (int s = 1; s < 4; s++)
      run_op("R7 wrap edge", 2'(s), 1'b0, 1'b1, fill(2'(s), 64'h7FFF_FFFF_FFFF_FFFF),
             fill(2'(s), 64'h8000_0000_0000_0001));
  endtask

  task automatic t_illegal();
    logic [W-1:0] a;
    logic [31:0] bad [3];
    a = {$urandom, $urandom, $urandom, $urandom};
    bad[0] = mk_insn(2'b01, 1'b0, 1'b0, 5'd1, 5'd1) ^ 32'h0100_0000;
    bad[1] = mk_insn(2'b01, 1'b0, 1'b0, 5'd1, 5'd1) | 32'h0002_0000;
    bad[2] = mk_insn(2'b01, 1'b0, 1'b0, 5'd1, 5'd1) ^ 32'h0000_0800;
    for (int i = 0; i < 3; i++) begin
      issue(bad[i], a, ~a);
      chk("R1 illegal passthrough", out_illegal && out_result == a, out_result, a);
    end
    issue(mk_insn(2'b01, 1'b0, 1'b0, 5'd1, 5'd1), a, ~a);
    chk("R1 legal flag low", !out_illegal, {127'd0, out_illegal}, '0);
  endtask

  task automatic t_regs();
    issue(mk_insn(2'b10, 1'b0, 1'b1, 5'd21, 5'd10), '0, '0);
    chk("R8 reg fields", out_src_reg == 5'd21 && out_dst_reg == 5'd10,
        {118'd0, out_src_reg, out_dst_reg}, {118'd0, 5'd21, 5'd10});
  endtask

  task automatic t_backpressure();
    logic [W-1:0] a1, a2, e1, e2;
    a1 = {4{32'h0102_0304}}; a2 = {4{32'h1111_2222}};
    e1 = model(2'b00, 1'b0, 1'b0, a1, a1);
    e2 = model(2'b01, 1'b1, 1'b1, a2, a1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_insn = mk_insn(2'b00, 1'b0, 1'b0, 5'd4, 5'd5); in_src_a = a1; in_src_b = a1;
    @(negedge clk);
    in_insn = mk_insn(2'b01, 1'b1, 1'b1, 5'd6, 5'd8); in_src_a = a2; in_src_b = a1;
    for (int c = 0; c < 3; c++) begin
      chk("R10 held while stalled", out_valid && !in_ready && out_result == e1 && out_dst_reg == 5'd5,
          out_result, e1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second op after release", out_valid && out_result == e2 && out_dst_reg == 5'd8,
        out_result, e2);
    @(negedge clk);
    chk("R9 drains", !out_valid, {127'd0, out_valid}, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rot90();
    t_rot270();
    t_sat_pos();
    t_sat_neg();
    t_wrap();
    t_illegal();
    t_regs();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule